// File: doc/BRIEF.md
# USB Endpoint Stall and Status Controller

This block holds the status of every endpoint of a 16-endpoint USB device controller. Endpoint slot 0 is the control OUT endpoint, slot 1 is the control IN endpoint, and slots 2 to 15 are data endpoints 1 to 14. A microprocessor sends 8-bit command codes. The upper nibble of a code picks stall or unstall, and the lower nibble picks the endpoint slot. The controller keeps these items for each slot:
- the stall flag
- a full flag for each of the two packet buffers
- the data toggle expected next
- whether the buffer holds a Setup packet
- whether a Setup packet was overwritten
- which buffer the CPU is working on

The USB side reports events as single-cycle pulses. One pulse marks a SETUP token. Another marks the end of the Setup data write. A third marks a completed packet and carries the buffer index. The CPU side sends pulses that acknowledge a Setup packet and that release a buffer. Any slot's status byte can be read at any time. A read strobe clears that slot's Setup-overwrite flag, but only once the Setup write has finished.

When an endpoint goes from stalled to unstalled, it is re-initialised. Both buffers are emptied, the CPU buffer select returns to the primary buffer, and the data toggle goes back to DATA0. A stalled control endpoint also leaves stall by itself when a SETUP token arrives.

Top module: `ep_stall_status`

## Requirements
- R1: After reset every slot's status byte reads 0x00.
- R2: `rd_data` always shows the status byte of slot `rd_ep`. The bit layout is: bit 7 stalled, bit 6 secondary buffer (index 1) full, bit 5 primary buffer (index 0) full, bit 4 next data PID (0 = DATA0, 1 = DATA1), bit 3 Setup overwritten, bit 2 Setup packet held, bit 1 CPU buffer select (0 primary, 1 secondary), bit 0 always 0.
- R3: Command 0x40 + n (n = 0..15) stalls slot n and clears its Setup-held bit. The command does nothing to a slot that is already stalled.
- R4: Command 0x80 + n on a stalled slot re-initialises it: it clears the stall flag, both full flags, the CPU select and the data PID. The same command on a slot that is not stalled changes nothing.
- R5: A SETUP token on a stalled control slot (0 or 1) unstalls and re-initialises it, as in R4. A SETUP token addressed to slots 2 to 15 is ignored.
- R6: A packet-done pulse sets the full flag of buffer `pkt_buf` in slot `pkt_ep` and inverts that slot's data PID.
- R7: A buffer-clear pulse clears the full flag of buffer `clr_buf` in slot `clr_ep`. It sets the CPU select to the other buffer.
- R8: A Setup-done pulse sets the Setup-held bit. A Setup-ack pulse clears it.
- R9: A SETUP token on a control slot whose Setup-held bit is 1 sets that slot's Setup-overwritten bit.
- R10: A read strobe clears the slot's Setup-overwritten bit only when no Setup write is open, that is, no SETUP token on that slot since its last Setup-done. If an overwrite happens in the same cycle as a read, the bit stays set.
- R11: A command is ignored when `cmd_valid` is low or when its upper nibble is neither 0x4 nor 0x8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 8 | Command code |
| rd_valid | input | 1 | Status read strobe |
| rd_ep | input | 4 | Slot whose status byte is shown |
| rd_data | output | 8 | Status byte of slot `rd_ep` |
| setup_tok | input | 1 | SETUP token received |
| setup_done | input | 1 | Setup data fully written |
| setup_ack | input | 1 | CPU acknowledged the Setup packet |
| setup_ep | input | 4 | Slot for the three Setup pulses |
| pkt_done | input | 1 | Packet completed |
| pkt_ep | input | 4 | Slot of the completed packet |
| pkt_buf | input | 1 | Buffer of the completed packet |
| buf_clr | input | 1 | CPU released a buffer |
| clr_ep | input | 4 | Slot of the released buffer |
| clr_buf | input | 1 | Index of the released buffer |

## Verification
Every pulse and command updates the slot state at the first rising edge after it is driven. `rd_data` is combinational, so the new status byte is visible straight after that same edge. The bench drives each stimulus on a falling edge and holds it for one cycle. It removes the stimulus on the next falling edge and then compares `rd_data` with the read strobe low, so a check never disturbs the overwrite flag. The same-cycle cases are driven together in one cycle, and the result is compared one edge later: read with overwrite, and packet with SETUP token.

// File: rtl/ep_stat_pkg.sv
`timescale 1ns/1ps
package ep_stat_pkg;

    typedef struct packed {
        logic       stall;
        logic [1:0] full;
        logic       pid;
        logic       ovw;
        logic       setup;
        logic       sel;
        logic       busy;
    } ep_state_t;

    function automatic logic [7:0] pack_status(ep_state_t s);
        return {s.stall, s.full[1], s.full[0], s.pid, s.ovw, s.setup, s.sel, 1'b0};
    endfunction

    function automatic ep_state_t reinit(ep_state_t s);
        ep_state_t r;
        r       = s;
        r.stall = 1'b0;
        r.full  = 2'b00;
        r.sel   = 1'b0;
        r.pid   = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/ep_cmd_decode.sv
`timescale 1ns/1ps
module ep_cmd_decode #(
    parameter int NUM_EP     = 16,
    parameter int OP_W       = 4,
    parameter int STALL_OP   = 4,
    parameter int UNSTALL_OP = 8,
    localparam int EP_W      = $clog2(NUM_EP),
    localparam int CODE_W    = EP_W + OP_W
) (
    input  logic              cmd_valid,
    input  logic [CODE_W-1:0] cmd_code,
    output logic [NUM_EP-1:0] stall_vec,
    output logic [NUM_EP-1:0] unstall_vec
);
    logic [OP_W-1:0] op;
    logic [EP_W-1:0] idx;
    logic            is_stall;
    logic            is_unstall;

    assign op         = cmd_code[CODE_W-1:EP_W];
    assign idx        = cmd_code[EP_W-1:0];
    assign is_stall   = cmd_valid && (op == STALL_OP[OP_W-1:0]);
    assign is_unstall = cmd_valid && (op == UNSTALL_OP[OP_W-1:0]);

    for (genvar i = 0; i < NUM_EP; i++) begin : g_dec
        assign stall_vec[i]   = is_stall   && (idx == EP_W'(i));
        assign unstall_vec[i] = is_unstall && (idx == EP_W'(i));
    end
endmodule

// File: rtl/ep_slot.sv
`timescale 1ns/1ps
module ep_slot
    import ep_stat_pkg::*;
#(
    parameter bit IS_CTRL = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       do_stall,
    input  logic       do_unstall,
    input  logic       setup_tok,
    input  logic       setup_done,
    input  logic       setup_ack,
    input  logic       pkt_done,
    input  logic       pkt_buf,
    input  logic       buf_clr,
    input  logic       clr_buf,
    input  logic       rd_hit,
    output logic [7:0] status
);
    ep_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (pkt_done) begin
            st_d.full[pkt_buf] = 1'b1;
            st_d.pid           = ~st_q.pid;
        end
        if (buf_clr) begin
            st_d.full[clr_buf] = 1'b0;
            st_d.sel           = ~clr_buf;
        end
        if (setup_ack) st_d.setup = 1'b0;
        if (setup_done) begin
            st_d.setup = 1'b1;
            st_d.busy  = 1'b0;
        end
        if (rd_hit && !st_q.busy) st_d.ovw = 1'b0;
        if (IS_CTRL && setup_tok) begin
            st_d.busy = 1'b1;
            if (st_q.setup) st_d.ovw = 1'b1;
            if (st_q.stall) st_d = reinit(st_d);
        end
        if (do_stall && !st_q.stall) begin
            st_d.stall = 1'b1;
            st_d.setup = 1'b0;
        end
        if (do_unstall && st_q.stall) st_d = reinit(st_d);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status = pack_status(st_q);

    p_stall_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        do_stall |=> st_q.stall);

    p_unstall_reinit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        do_unstall && st_q.stall |=> !st_q.stall && st_q.full == 2'b00 && !st_q.pid && !st_q.sel);

    p_setup_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        IS_CTRL && setup_tok && st_q.stall && !do_stall |=> !st_q.stall && st_q.full == 2'b00);

    p_setup_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !IS_CTRL && setup_tok && st_q.stall && !do_unstall |=> st_q.stall);

    p_pid_toggle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done && !(do_unstall && st_q.stall) && !(IS_CTRL && setup_tok && st_q.stall)
        |=> st_q.pid != $past(st_q.pid));

    p_ovw_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        IS_CTRL && setup_tok && st_q.setup |=> st_q.ovw);
endmodule

// File: rtl/ep_stall_status.sv
`timescale 1ns/1ps
module ep_stall_status #(
    parameter int NUM_EP    = 16,
    parameter int NUM_CTRL  = 2,
    parameter int OP_W      = 4,
    localparam int EP_W     = $clog2(NUM_EP),
    localparam int CODE_W   = EP_W + OP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [CODE_W-1:0] cmd_code,
    input  logic              rd_valid,
    input  logic [EP_W-1:0]   rd_ep,
    output logic [7:0]        rd_data,
    input  logic              setup_tok,
    input  logic              setup_done,
    input  logic              setup_ack,
    input  logic [EP_W-1:0]   setup_ep,
    input  logic              pkt_done,
    input  logic [EP_W-1:0]   pkt_ep,
    input  logic              pkt_buf,
    input  logic              buf_clr,
    input  logic [EP_W-1:0]   clr_ep,
    input  logic              clr_buf
);
    logic [NUM_EP-1:0] stall_vec, unstall_vec;
    logic [7:0]        status_arr [NUM_EP];

    ep_cmd_decode #(.NUM_EP(NUM_EP), .OP_W(OP_W)) u_dec (
        .cmd_valid   (cmd_valid),
        .cmd_code    (cmd_code),
        .stall_vec   (stall_vec),
        .unstall_vec (unstall_vec)
    );

    for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
        logic su_hit;
        assign su_hit = (setup_ep == EP_W'(i));
        ep_slot #(.IS_CTRL(i < NUM_CTRL)) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .do_stall   (stall_vec[i]),
            .do_unstall (unstall_vec[i]),
            .setup_tok  (setup_tok  && su_hit),
            .setup_done (setup_done && su_hit),
            .setup_ack  (setup_ack  && su_hit),
            .pkt_done   (pkt_done && (pkt_ep == EP_W'(i))),
            .pkt_buf    (pkt_buf),
            .buf_clr    (buf_clr && (clr_ep == EP_W'(i))),
            .clr_buf    (clr_buf),
            .rd_hit     (rd_valid && (rd_ep == EP_W'(i))),
            .status     (status_arr[i])
        );
    end

    assign rd_data = status_arr[rd_ep];
endmodule

// File: tb/sim_ep_stall_status.sv
`timescale 1ns/1ps
module sim_ep_stall_status;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [7:0] cmd_code = '0;
    logic       rd_valid = 1'b0;
    logic [3:0] rd_ep = '0;
    logic [7:0] rd_data;
    logic       setup_tok = 1'b0, setup_done = 1'b0, setup_ack = 1'b0;
    logic [3:0] setup_ep = '0;
    logic       pkt_done = 1'b0;
    logic [3:0] pkt_ep = '0;
    logic       pkt_buf = 1'b0;
    logic       buf_clr = 1'b0;
    logic [3:0] clr_ep = '0;
    logic       clr_buf = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    ep_stall_status u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .rd_valid(rd_valid), .rd_ep(rd_ep), .rd_data(rd_data),
        .setup_tok(setup_tok), .setup_done(setup_done), .setup_ack(setup_ack),
        .setup_ep(setup_ep), .pkt_done(pkt_done), .pkt_ep(pkt_ep), .pkt_buf(pkt_buf),
        .buf_clr(buf_clr), .clr_ep(clr_ep), .clr_buf(clr_buf)
    );

    task automatic chk(string req, logic [3:0] ep, logic [7:0] exp);
        rd_ep = ep;
        #1;
        n_chk++;
        if (rd_data !== exp) begin
            n_bad++;
            $display("FAIL %s slot %0d: actual %02h expected %02h", req, ep, rd_data, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        cmd_valid = 0; rd_valid = 0; setup_tok = 0; setup_done = 0; setup_ack = 0;
        pkt_done = 0; buf_clr = 0;
    endtask

    task automatic cmd(logic [7:0] c);
        cmd_valid = 1; cmd_code = c; tick();
    endtask
    task automatic pkt(logic [3:0] ep, logic b);
        pkt_done = 1; pkt_ep = ep; pkt_buf = b; tick();
    endtask
    task automatic bclr(logic [3:0] ep, logic b);
        buf_clr = 1; clr_ep = ep; clr_buf = b; tick();
    endtask
    task automatic tok(logic [3:0] ep);
        setup_tok = 1; setup_ep = ep; tick();
    endtask
    task automatic sdone(logic [3:0] ep);
        setup_done = 1; setup_ep = ep; tick();
    endtask
    task automatic sack(logic [3:0] ep);
        setup_ack = 1; setup_ep = ep; tick();
    endtask
    task automatic rd(logic [3:0] ep);
        rd_valid = 1; rd_ep = ep; tick();
    endtask

    task automatic t_reset();
        for (int i = 0; i < 16; i++) chk("R1", 4'(i), 8'h00);
    endtask

    task automatic t_stall();
        cmd(8'h45); chk("R3", 4'd5, 8'h80);
        cmd(8'h45); chk("R3", 4'd5, 8'h80);
        chk("R2", 4'd4, 8'h00);
    endtask

    task automatic t_buffers();
        pkt(4'd3, 1'b0);  chk("R6", 4'd3, 8'h30);
        pkt(4'd3, 1'b1);  chk("R6", 4'd3, 8'h60);
        bclr(4'd3, 1'b0); chk("R7", 4'd3, 8'h42);
    endtask

    task automatic t_unstall();
        cmd(8'h43); chk("R3", 4'd3, 8'hC2);
        cmd(8'h83); chk("R4", 4'd3, 8'h00);
        pkt(4'd3, 1'b0); chk("R6", 4'd3, 8'h30);
        cmd(8'h83); chk("R4", 4'd3, 8'h30);
    endtask

    task automatic t_setup();
        tok(4'd0);   chk("R8", 4'd0, 8'h00);
        sdone(4'd0); chk("R8", 4'd0, 8'h04);
        tok(4'd0);   chk("R9", 4'd0, 8'h0C);
        rd(4'd0);    chk("R10", 4'd0, 8'h0C);
        sdone(4'd0); chk("R10", 4'd0, 8'h0C);
        rd(4'd0);    chk("R10", 4'd0, 8'h04);
        setup_tok = 1; setup_ep = 4'd0; rd_valid = 1; rd_ep = 4'd0; tick();
        chk("R10", 4'd0, 8'h0C);
        sdone(4'd0);
        sack(4'd0);  chk("R8", 4'd0, 8'h08);
        rd(4'd0);    chk("R10", 4'd0, 8'h00);
        sdone(4'd0); chk("R8", 4'd0, 8'h04);
        cmd(8'h40);  chk("R3", 4'd0, 8'h80);
        cmd(8'h80);  chk("R4", 4'd0, 8'h00);
    endtask

    task automatic t_setup_unstall();
        cmd(8'h41);      chk("R3", 4'd1, 8'h80);
        pkt(4'd1, 1'b0); chk("R6", 4'd1, 8'hB0);
        tok(4'd1);       chk("R5", 4'd1, 8'h00);
        sdone(4'd1);     sack(4'd1);
        cmd(8'h46);      chk("R3", 4'd6, 8'h80);
        tok(4'd6);       chk("R5", 4'd6, 8'h80);
        cmd(8'h47);
        pkt_done = 1; pkt_ep = 4'd7; pkt_buf = 1'b1;
        setup_tok = 1; setup_ep = 4'd7; tick();
        chk("R5", 4'd7, 8'hD0);
    endtask

    task automatic t_ignore();
        pkt(4'd2, 1'b1); chk("R6", 4'd2, 8'h50);
        cmd_code = 8'h42; tick(); chk("R11", 4'd2, 8'h50);
        cmd(8'h22); chk("R11", 4'd2, 8'h50);
        cmd(8'hC2); chk("R11", 4'd2, 8'h50);
        cmd(8'h02); chk("R11", 4'd2, 8'h50);
        chk("R11", 4'd5, 8'h80);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_stall();
        t_buffers();
        t_unstall();
        t_setup();
        t_setup_unstall();
        t_ignore();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL R1 watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule